// File: doc/BRIEF.md
# Three-Byte Serial Register Writer

This block is a bus master that turns host register-write requests into chip-select-framed serial traffic for a display driver. It drives three output lines: an active-low chip select, a serial clock and a serial data line. Between transfers all three lines rest high. A host offers a 16-bit register index and a 16-bit value on a valid/ready handshake. A full write becomes two frames of 24 bits each. The first frame is an index-prefix byte followed by the index. The second is a value-prefix byte followed by the value. An index-only mode sends just the first frame. This is how the driver's pixel-RAM write register is selected before streaming begins.

All bit timing is built from a "unit" of `UNIT_CLKS` system clocks. A free-running tick divider produces one tick per unit, and a unit counter measures how long each state lasts. The sequencer has these states:

- ST_IDLE: bus resting, ready high.
- ST_LEAD: chip-select set-up time.
- ST_LOW: clock low, data presented.
- ST_HIGH: clock high, data held.
- ST_GAP: clock and data high between bits.
- ST_TAIL: chip select released, bus idle.
- ST_FINISH: one-cycle completion.

The transitions are:

- accept: ST_IDLE to ST_LEAD.
- lead_done: ST_LEAD to ST_LOW.
- fall_done: ST_LOW to ST_HIGH.
- rise_done: ST_HIGH to ST_GAP.
- next_bit: ST_GAP to ST_LOW.
- frame_end: ST_GAP to ST_TAIL.
- second_frame: ST_TAIL to ST_LEAD.
- close: ST_TAIL to ST_FINISH.
- release: ST_FINISH to ST_IDLE.

Top module: `sreg_writer`

## Requirements
- R1: While in reset and whenever no request is in progress, `cs_n`, `sclk` and `sdo` are all 1, `req_ready` is 1 and `done` is 0.
- R2: On the clock edge where `req_valid` is sampled high with `req_ready` high, the request is accepted. From the next cycle, `cs_n` is 0 while `sclk` and `sdo` stay 1 for `LEAD_UNITS` units, before the first clock fall.
- R3: Each frame carries exactly 24 bits, most significant first. Bits 23..16 are the prefix byte, bits 15..8 are the high byte of the word and bits 7..0 are the low byte.
- R4: Each bit takes three phases. First `sclk`=0 with `sdo` equal to the bit for `LOW_UNITS` units. Then `sclk`=1 with `sdo` unchanged for `HIGH_UNITS` units. Then `sclk`=1 and `sdo`=1 for `GAP_UNITS` units.
- R5: After the last bit's gap, `cs_n` returns to 1 with `sclk`=`sdo`=1 for `TAIL_UNITS` units.
- R6: A full write (`req_index_only`=0) sends a frame with prefix `IDX_PREFIX` (0x70) carrying `req_index`. It then sends a frame with prefix `DATA_PREFIX` (0x72) carrying `req_value`.
- R7: An index-only request (`req_index_only`=1) sends only the 0x70 frame carrying `req_index`.
- R8: `req_ready` is 0 from the cycle after acceptance until the request completes. `done` is 1 for exactly one cycle, directly after the final tail, with `req_ready` still 0. Requests presented while `req_ready` is 0 are ignored and do not alter the transfer in progress.
- R9: One unit equals exactly `UNIT_CLKS` clock cycles. For example, the chip-select lead lasts `LEAD_UNITS*UNIT_CLKS` cycles.
- R10: `sdo` never changes in a cycle where `sclk` rises, and `sclk` toggles only while `cs_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_index_only | input | 1 | 1: send only the index frame |
| req_index | input | WORD_W | Register index |
| req_value | input | WORD_W | Register value |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, idles high |

## Verification
The done pulse and a new request can fall in the same cycle. The bench provokes this by holding `req_valid` high through the whole transfer, with fresh fields loaded mid-transfer. The per-cycle reference model expects no acceptance in the ST_FINISH cycle, where `req_ready` is 0. It expects acceptance on the first idle cycle that follows. The serial frames decoded from the lines must then show the new request and no trace of the ignored one.

// File: rtl/sreg_writer_pkg.sv
package sreg_writer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_LOW    = 3'd2,
        ST_HIGH   = 3'd3,
        ST_GAP    = 3'd4,
        ST_TAIL   = 3'd5,
        ST_FINISH = 3'd6
    } wr_state_t;

    function automatic int max_of5(int a, int b, int c, int d, int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/sw_tick_div.sv
module sw_tick_div #(
    parameter int UNIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(UNIT_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sw_unit_count.sv
module sw_unit_count #(
    parameter int MAX_UNITS = 10,
    localparam int UW = $clog2(MAX_UNITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [UW-1:0] units,
    output logic          expire
);
    logic [UW-1:0] cnt_q;

    assign expire = tick && (cnt_q == units - UW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sw_frame_shift.sv
module sw_frame_shift #(
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] load_word,
    input  logic                  shift,
    output logic                  msb,
    output logic                  last
);
    localparam int BW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] sh_q;
    logic [BW-1:0]         bit_q;

    assign msb  = sh_q[FRAME_BITS-1];
    assign last = (bit_q == BW'(FRAME_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '1;
            bit_q <= '0;
        end else if (load) begin
            sh_q  <= load_word;
            bit_q <= '0;
        end else if (shift) begin
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
            bit_q <= bit_q + 1'b1;
        end
    end
endmodule

// File: rtl/sreg_writer.sv
module sreg_writer
    import sreg_writer_pkg::*;
#(
    parameter int         UNIT_CLKS   = 8,
    parameter int         LEAD_UNITS  = 10,
    parameter int         LOW_UNITS   = 1,
    parameter int         HIGH_UNITS  = 1,
    parameter int         GAP_UNITS   = 3,
    parameter int         TAIL_UNITS  = 1,
    parameter int         PREFIX_W    = 8,
    parameter int         WORD_W      = 16,
    parameter logic [7:0] IDX_PREFIX  = 8'h70,
    parameter logic [7:0] DATA_PREFIX = 8'h72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_index_only,
    input  logic [WORD_W-1:0] req_index,
    input  logic [WORD_W-1:0] req_value,
    output logic              done,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdo
);
    localparam int FRAME_BITS = PREFIX_W + WORD_W;
    localparam int MAXU = max_of5(LEAD_UNITS, LOW_UNITS, HIGH_UNITS, GAP_UNITS, TAIL_UNITS);
    localparam int UW   = $clog2(MAXU + 1);

    wr_state_t state_q, state_d;

    logic                  tick, expire, restart;
    logic [UW-1:0]         units;
    logic                  ld, shift, msb, last;
    logic [FRAME_BITS-1:0] ld_word;
    logic [WORD_W-1:0]     val_q;
    logic                  idx_only_q, second_q;
    logic                  accept;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign restart = (state_d != state_q);

    sw_tick_div #(.UNIT_CLKS(UNIT_CLKS)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    sw_unit_count #(.MAX_UNITS(MAXU)) u_units (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .units   (units),
        .expire  (expire)
    );

    sw_frame_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_word (ld_word),
        .shift     (shift),
        .msb       (msb),
        .last      (last)
    );

    // Duration of the current state in units
    always_comb begin
        unique case (state_q)
            ST_LEAD: units = UW'(LEAD_UNITS);
            ST_LOW:  units = UW'(LOW_UNITS);
            ST_HIGH: units = UW'(HIGH_UNITS);
            ST_GAP:  units = UW'(GAP_UNITS);
            ST_TAIL: units = UW'(TAIL_UNITS);
            default: units = UW'(1);
        endcase
    end

    // Next state and datapath control
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        shift   = 1'b0;
        ld_word = {IDX_PREFIX[PREFIX_W-1:0], req_index};
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    ld      = 1'b1;
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: if (expire) state_d = ST_LOW;
            ST_LOW:  if (expire) state_d = ST_HIGH;
            ST_HIGH: if (expire) state_d = ST_GAP;
            ST_GAP: begin
                if (expire) begin
                    if (last) begin
                        state_d = ST_TAIL;
                    end else begin
                        shift   = 1'b1;
                        state_d = ST_LOW;
                    end
                end
            end
            ST_TAIL: begin
                if (expire) begin
                    if (!second_q && !idx_only_q) begin
                        ld      = 1'b1;
                        ld_word = {DATA_PREFIX[PREFIX_W-1:0], val_q};
                        state_d = ST_LEAD;
                    end else begin
                        state_d = ST_FINISH;
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            val_q      <= '0;
            idx_only_q <= 1'b0;
            second_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                val_q      <= req_value;
                idx_only_q <= req_index_only;
                second_q   <= 1'b0;
            end else if (state_q == ST_TAIL && state_d == ST_LEAD) begin
                second_q <= 1'b1;
            end
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        cs_n      = 1'b1;
        sclk      = 1'b1;
        sdo       = 1'b1;
        req_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_LEAD:   cs_n = 1'b0;
            ST_LOW: begin
                cs_n = 1'b0;
                sclk = 1'b0;
                sdo  = msb;
            end
            ST_HIGH: begin
                cs_n = 1'b0;
                sdo  = msb;
            end
            ST_GAP:    cs_n = 1'b0;
            ST_TAIL:   cs_n = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/sreg_writer_chk.sv
module sreg_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic cs_n,
    input logic sclk,
    input logic sdo
);
    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk && sdo));

    // R2
    lead_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (sclk && sdo && !req_ready));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!req_ready && cs_n));

    // R8
    busy_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready);

    // R10
    rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdo));

    // R10
    fall_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !cs_n);
endmodule

bind sreg_writer sreg_writer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdo       (sdo)
);

// File: tb/sreg_writer_bench.sv
`timescale 1ns/1ps
module sreg_writer_bench;
    localparam int U    = 3;
    localparam int LEAD = 10;
    localparam int LOWU = 1;
    localparam int HIU  = 1;
    localparam int GAPU = 3;
    localparam int TAIL = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_index_only = 1'b0;
    logic [15:0] req_index = '0;
    logic [15:0] req_value = '0;
    logic        req_ready, done, cs_n, sclk, sdo;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    typedef struct {
        bit    cs;
        bit    sc;
        bit    sd;
        bit    rd;
        bit    dn;
        string tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [23:0] rx_q[$];
    logic [23:0] rx_sh = '0;
    int          rx_n = 0;

    always #2 clk = ~clk;

    sreg_writer #(
        .UNIT_CLKS(U), .LEAD_UNITS(LEAD), .LOW_UNITS(LOWU), .HIGH_UNITS(HIU),
        .GAP_UNITS(GAPU), .TAIL_UNITS(TAIL), .PREFIX_W(8), .WORD_W(16),
        .IDX_PREFIX(8'h70), .DATA_PREFIX(8'h72)
    ) u_sreg_writer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_index_only(req_index_only), .req_index(req_index), .req_value(req_value),
        .done(done), .cs_n(cs_n), .sclk(sclk), .sdo(sdo)
    );

    function automatic void add(int n, bit cs, bit sc, bit sd, bit rd, bit dn, string tag);
        exp_t e;
        e.cs = cs; e.sc = sc; e.sd = sd; e.rd = rd; e.dn = dn; e.tag = tag;
        for (int i = 0; i < n; i++) exp_q.push_back(e);
    endfunction

    function automatic void add_frame(logic [23:0] w);
        add(LEAD*U, 0, 1, 1, 0, 0, "R2");
        for (int i = 23; i >= 0; i--) begin
            add(LOWU*U, 0, 0, w[i], 0, 0, "R4");
            add(HIU*U,  0, 1, w[i], 0, 0, "R4");
            add(GAPU*U, 0, 1, 1,    0, 0, "R4");
        end
        add(TAIL*U, 1, 1, 1, 0, 0, "R5");
    endfunction

    function automatic void add_req(logic [15:0] idx, logic [15:0] val, bit io);
        add_frame({8'h70, idx});
        if (!io) add_frame({8'h72, val});
        add(1, 1, 1, 1, 0, 1, "R8");
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Cycle-by-cycle reference model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                e.cs = 1; e.sc = 1; e.sd = 1; e.rd = 1; e.dn = 0; e.tag = "R1";
            end else begin
                e = exp_q.pop_front();
            end
            check({cs_n, sclk, sdo, req_ready, done} == {e.cs, e.sc, e.sd, e.rd, e.dn},
                  e.tag, "cs/sclk/sdo/ready/done",
                  int'({cs_n, sclk, sdo, req_ready, done}),
                  int'({e.cs, e.sc, e.sd, e.rd, e.dn}));
            if (e.rd && req_valid) add_req(req_index, req_value, req_index_only);
        end
    end

    // Serial receiver: capture on the rising clock edge inside a frame
    always @(posedge sclk) begin
        if (!cs_n) begin
            rx_sh = {rx_sh[22:0], sdo};
            rx_n++;
        end
    end

    always @(posedge cs_n) begin
        if (rst_n) begin
            check(rx_n == 24, "R3", "bits per frame", rx_n, 24);
            rx_q.push_back(rx_sh);
        end
        rx_n = 0;
    end

    task automatic drive(bit v, bit io, logic [15:0] idx, logic [15:0] val);
        @(posedge clk);
        #1;
        req_valid = v; req_index_only = io; req_index = idx; req_value = val;
    endtask

    task automatic issue(bit io, logic [15:0] idx, logic [15:0] val);
        drive(1'b1, io, idx, val);
        drive(1'b0, 1'b0, 16'h0, 16'h0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        #0.1;
        while (exp_q.size() != 0) begin
            @(negedge clk);
            #0.1;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_frames(logic [23:0] f0, logic [23:0] f1, logic [23:0] f2,
                                 int n, string tag);
        logic [23:0] want[3];
        want[0] = f0; want[1] = f1; want[2] = f2;
        check(rx_q.size() == n, tag, "frame count", rx_q.size(), n);
        for (int i = 0; i < n && i < rx_q.size(); i++)
            check(rx_q[i] == want[i], tag, "frame content", int'(rx_q[i]), int'(want[i]));
        rx_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        check({cs_n, sclk, sdo, req_ready, done} == 5'b11110, "R1", "reset outputs",
              int'({cs_n, sclk, sdo, req_ready, done}), 5'h1e);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6: full write
        issue(1'b0, 16'h0044, 16'hA5C3);
        wait_idle();
        expect_frames(24'h700044, 24'h72A5C3, 24'h0, 2, "R6");

        // R7: index-only frame
        issue(1'b1, 16'h0022, 16'hFFFF);
        wait_idle();
        expect_frames(24'h700022, 24'h0, 24'h0, 1, "R7");

        // R3: extreme data patterns
        issue(1'b0, 16'hFFFF, 16'h0000);
        wait_idle();
        expect_frames(24'h70FFFF, 24'h720000, 24'h0, 2, "R3");

        // R9: lead duration in clocks
        drive(1'b1, 1'b0, 16'h8001, 16'h5AA5);
        drive(1'b0, 1'b0, 16'h0, 16'h0);
        @(negedge clk);
        while (cs_n) @(negedge clk);
        n = 0;
        while (sclk) begin
            @(negedge clk);
            n++;
        end
        check(n == LEAD*U, "R9", "lead clocks", n, LEAD*U);
        // R8: a request while busy is ignored
        drive(1'b1, 1'b1, 16'h1111, 16'h2222);
        drive(1'b0, 1'b0, 16'h0, 16'h0);
        wait_idle();
        expect_frames(24'h708001, 24'h725AA5, 24'h0, 2, "R8");

        // R8: valid held through done; the new request is taken after completion
        drive(1'b1, 1'b0, 16'h0011, 16'h1234);
        @(negedge clk);
        #0.1;
        while (exp_q.size() == 0) begin
            @(negedge clk);
            #0.1;
        end
        drive(1'b1, 1'b1, 16'h0033, 16'h0000);
        while (exp_q.size() != 0) begin
            @(negedge clk);
            #0.1;
        end
        @(negedge clk);
        #0.1;
        check(exp_q.size() != 0, "R8", "accept after done", exp_q.size(), 1);
        drive(1'b0, 1'b0, 16'h0, 16'h0);
        wait_idle();
        expect_frames(24'h700011, 24'h721234, 24'h700033, 3, "R8");

        // R10 and R5 are covered on every cycle by the model above
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule